// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Decoder

This block sits between an instruction fetch buffer and the issue logic. It consumes a stream of 16-bit halfwords over a valid/ready handshake. For each instruction it works out the length from the top six bits of the first halfword. Short instructions are one halfword and long ones are two. It gathers the second halfword when one is needed and emits one decoded record over a second valid/ready handshake.

The record carries the opcode, the instruction form, the condition code of a branch, the two register fields and a 32-bit sign-extended immediate or displacement. It also carries a sub-opcode, two flags for undefined encodings, and the address of the instruction's first halfword. Addresses are counted inside the block. They start at a reset value and step by two per accepted halfword. A flush input reloads the count and drops any half-built instruction.

Back-pressure rules: a record, once valid, stays unchanged until `out_ready` takes it. While a record waits, `in_ready` is low, so no halfword is accepted. During a flush `in_ready` is also low. The input side may insert idle cycles between the two halfwords of a long instruction. The first halfword is held across the gap.

Top module: `insn_stream_decoder`

## Requirements
- R1: A halfword is accepted in a cycle where `in_valid` and `in_ready` are both high. `in_ready` is low while `flush` is high, and also while `out_valid` is high and `out_ready` is low. Otherwise it is high.
- R2: Bits 15:10 of a first halfword below 0x28 make a one-halfword instruction; 0x28 and above make a two-halfword instruction. `out_valid` rises in the cycle after the last halfword is accepted, drops after a cycle where `out_valid` and `out_ready` are both high with no new completion, and is low after reset.
- R3: `out_form` is 1 for opcodes 0x00-0x0F, 2 for 0x10-0x1F, 3 for 0x20-0x27 (branches), 4 for 0x2A and 0x2B, 5 for 0x28, 0x29 and 0x2C-0x2F, 7 for 0x3E, and 6 for the rest of 0x30-0x3F.
- R4: For a branch, `out_opcode` is bits 15:9 of the first halfword (0x40-0x4F) and `out_cond` is bits 12:9. For any other instruction `out_opcode` is bits 15:10 zero-extended to 7 bits and `out_cond` is 0. `out_reg2` is bits 9:5 and `out_reg1` is bits 4:0, except for forms 3 and 4, where both are 0.
- R5: `out_imm` is bits 4:0 sign-extended for form 2, and bits 8:0 sign-extended for form 3. For forms 5 and 6 it is the second halfword sign-extended. For form 4 it is {first[9:0], second} sign-extended. For forms 1 and 7 it is 0.
- R6: `out_ill_op` is high exactly for opcodes 0x1B, 0x32 and 0x36.
- R7: For opcode 0x1F, `out_subop` is bits 4:0 of the halfword. `out_ill_sub` is high when that value is 0x04-0x07 or 0x10-0x1F.
- R8: For form 7, `out_subop` is bits 15:10 of the second halfword. `out_ill_sub` is high unless that value is 0x00, 0x02-0x07 or 0x0B. For every other instruction both `out_subop` and `out_ill_sub` are 0.
- R9: While `out_valid` is high and `out_ready` is low (no flush), every record output holds its value and `out_valid` stays high.
- R10: A flush drops any valid record and any held first halfword. The next halfword accepted is a first halfword, and its address is `flush_addr`.
- R11: `out_addr` is the address of the instruction's first halfword. The address starts at `RESET_ADDR` and rises by 2, modulo 2^ADDR_W, for each halfword accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Discard partial state and restart the address count |
| flush_addr | input | ADDR_W | Address of the next halfword after a flush |
| in_valid | input | 1 | Halfword available |
| in_ready | output | 1 | Halfword can be taken |
| in_half | input | 16 | Instruction halfword |
| out_valid | output | 1 | Decoded record available |
| out_ready | input | 1 | Downstream takes the record |
| out_addr | output | ADDR_W | Address of the first halfword |
| out_opcode | output | 7 | Primary opcode, 7 bits for branches |
| out_form | output | 3 | Instruction form 1..7 |
| out_cond | output | 4 | Branch condition code |
| out_reg1 | output | 5 | Low register field |
| out_reg2 | output | 5 | High register field |
| out_imm | output | 32 | Sign-extended immediate or displacement |
| out_subop | output | 6 | Bit-string or floating-point sub-opcode |
| out_ill_op | output | 1 | Undefined primary opcode |
| out_ill_sub | output | 1 | Undefined sub-opcode |

## Verification
The bench builds the decoder with a 20-bit address and a reset address of 0xFFFF0. The address count therefore wraps past zero after eight halfwords, so the modulo rule on `out_addr` is exercised early and often. Random halfwords reach every opcode and sub-opcode. Random stalls, gaps between halves and flushes in the middle of a long instruction cover the holding and discard paths.

// File: rtl/insn_dec_pkg.sv
package insn_dec_pkg;

  localparam int HW_W   = 16;
  localparam int OP6_W  = 6;
  localparam int OP7_W  = 7;
  localparam int REG_W  = 5;
  localparam int IMM_W  = 32;
  localparam int SUB_W  = 6;
  localparam int COND_W = 4;

  // opcode boundaries of the 6-bit primary map
  localparam logic [OP6_W-1:0] OP_FIRST_LONG = 6'h28;
  localparam logic [OP6_W-1:0] OP_BITSTR     = 6'h1F;
  localparam logic [OP6_W-1:0] OP_FLOAT      = 6'h3E;

  typedef enum logic [2:0] {
    FORM_NONE = 3'd0,
    FORM_I    = 3'd1,
    FORM_II   = 3'd2,
    FORM_III  = 3'd3,
    FORM_IV   = 3'd4,
    FORM_V    = 3'd5,
    FORM_VI   = 3'd6,
    FORM_VII  = 3'd7
  } form_e;

  typedef struct packed {
    logic [OP7_W-1:0]  opcode;
    form_e             form;
    logic [COND_W-1:0] cond;
    logic [REG_W-1:0]  reg1;
    logic [REG_W-1:0]  reg2;
    logic [IMM_W-1:0]  imm;
    logic [SUB_W-1:0]  subop;
    logic              ill_op;
    logic              ill_sub;
  } dec_rec_t;

endpackage

// File: rtl/insn_form_class.sv
module insn_form_class
  import insn_dec_pkg::*;
(
  input  logic [HW_W-1:0] first_hw,
  output form_e           form,
  output logic            is_long
);

  logic [OP6_W-1:0] op6;
  assign op6 = first_hw[HW_W-1 -: OP6_W];

  always_comb begin
    if (op6[5:4] == 2'b00)
      form = FORM_I;
    else if (op6[5:4] == 2'b01)
      form = FORM_II;
    else if (op6[5:3] == 3'b100)
      form = FORM_III;
    else if (op6 == 6'h2A || op6 == 6'h2B)
      form = FORM_IV;
    else if (op6[5:4] == 2'b10)
      form = FORM_V;
    else if (op6 == OP_FLOAT)
      form = FORM_VII;
    else
      form = FORM_VI;
  end

  assign is_long = (op6 >= OP_FIRST_LONG);

endmodule

// File: rtl/insn_subop_legal.sv
module insn_subop_legal
  import insn_dec_pkg::*;
(
  input  logic             bs_sel,
  input  logic             fp_sel,
  input  logic [SUB_W-1:0] code,
  output logic             bad
);

  logic bs_bad;
  logic fp_bad;

  // bit-string group: 0x00-0x03 and 0x08-0x0F are the defined codes
  assign bs_bad = code[4] | (code[4:2] == 3'b001);

  // floating-point group: 0x00, 0x02-0x07 and 0x0B are the defined codes
  always_comb begin
    case (code)
      6'h00, 6'h02, 6'h03, 6'h04, 6'h05, 6'h06, 6'h07, 6'h0B: fp_bad = 1'b0;
      default:                                             fp_bad = 1'b1;
    endcase
  end

  assign bad = (bs_sel & bs_bad) | (fp_sel & fp_bad);

endmodule

// File: rtl/insn_field_build.sv
module insn_field_build
  import insn_dec_pkg::*;
(
  input  logic [HW_W-1:0] first_hw,
  input  logic [HW_W-1:0] second_hw,
  input  form_e           form,
  output dec_rec_t        rec
);

  localparam int IMM5_W  = 5;
  localparam int DISP9_W = 9;
  localparam int HI26_W  = 10;

  logic [OP6_W-1:0] op6;
  logic             bs_sel;
  logic             fp_sel;
  logic [SUB_W-1:0] sub_code;
  logic             sub_bad;

  assign op6    = first_hw[HW_W-1 -: OP6_W];
  assign bs_sel = (form == FORM_II) && (op6 == OP_BITSTR);
  assign fp_sel = (form == FORM_VII);

  always_comb begin
    if (fp_sel)
      sub_code = second_hw[HW_W-1 -: SUB_W];
    else if (bs_sel)
      sub_code = {1'b0, first_hw[IMM5_W-1:0]};
    else
      sub_code = '0;
  end

  insn_subop_legal u_legal (
    .bs_sel (bs_sel),
    .fp_sel (fp_sel),
    .code   (sub_code),
    .bad    (sub_bad)
  );

  always_comb begin
    rec         = '0;
    rec.form    = form;
    rec.opcode  = {1'b0, op6};
    rec.reg1    = first_hw[REG_W-1:0];
    rec.reg2    = first_hw[2*REG_W-1:REG_W];
    rec.subop   = sub_code;
    rec.ill_sub = sub_bad;
    rec.ill_op  = (op6 == 6'h1B) || (op6 == 6'h32) || (op6 == 6'h36);
    case (form)
      FORM_II: begin
        rec.imm = {{(IMM_W-IMM5_W){first_hw[IMM5_W-1]}}, first_hw[IMM5_W-1:0]};
      end
      FORM_III: begin
        rec.opcode = first_hw[HW_W-1 -: OP7_W];
        rec.cond   = first_hw[DISP9_W+COND_W-1:DISP9_W];
        rec.reg1   = '0;
        rec.reg2   = '0;
        rec.imm    = {{(IMM_W-DISP9_W){first_hw[DISP9_W-1]}}, first_hw[DISP9_W-1:0]};
      end
      FORM_IV: begin
        rec.reg1 = '0;
        rec.reg2 = '0;
        rec.imm  = {{(IMM_W-HI26_W-HW_W){first_hw[HI26_W-1]}},
                    first_hw[HI26_W-1:0], second_hw};
      end
      FORM_V, FORM_VI: begin
        rec.imm = {{(IMM_W-HW_W){second_hw[HW_W-1]}}, second_hw};
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/insn_stream_decoder.sv
module insn_stream_decoder
  import insn_dec_pkg::*;
#(
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [HW_W-1:0]   in_half,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [ADDR_W-1:0] out_addr,
  output logic [OP7_W-1:0]  out_opcode,
  output logic [2:0]        out_form,
  output logic [COND_W-1:0] out_cond,
  output logic [REG_W-1:0]  out_reg1,
  output logic [REG_W-1:0]  out_reg2,
  output logic [IMM_W-1:0]  out_imm,
  output logic [SUB_W-1:0]  out_subop,
  output logic              out_ill_op,
  output logic              out_ill_sub
);

  localparam logic [ADDR_W-1:0] HW_BYTES = ADDR_W'(2);

  // holding state for a two-halfword instruction
  logic              pend_q;
  logic [HW_W-1:0]   first_q;
  logic [ADDR_W-1:0] first_addr_q;
  logic [ADDR_W-1:0] next_addr_q;

  // output stage
  logic              valid_q;
  logic [ADDR_W-1:0] addr_q;
  dec_rec_t          rec_q;

  logic [HW_W-1:0]   first_hw;
  logic [HW_W-1:0]   second_hw;
  form_e             cls_form;
  logic              cls_long;
  dec_rec_t          built;
  logic              take;
  logic              complete;

  assign in_ready = !flush && (!valid_q || out_ready);
  assign take     = in_valid && in_ready;

  assign first_hw  = pend_q ? first_q : in_half;
  assign second_hw = pend_q ? in_half : '0;

  insn_form_class u_class (
    .first_hw (first_hw),
    .form     (cls_form),
    .is_long  (cls_long)
  );

  insn_field_build u_build (
    .first_hw  (first_hw),
    .second_hw (second_hw),
    .form      (cls_form),
    .rec       (built)
  );

  assign complete = take && (pend_q || !cls_long);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q       <= 1'b0;
      first_q      <= '0;
      first_addr_q <= '0;
      next_addr_q  <= RESET_ADDR;
    end else if (flush) begin
      pend_q      <= 1'b0;
      next_addr_q <= flush_addr;
    end else if (take) begin
      next_addr_q <= next_addr_q + HW_BYTES;
      if (complete) begin
        pend_q <= 1'b0;
      end else begin
        pend_q       <= 1'b1;
        first_q      <= in_half;
        first_addr_q <= next_addr_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
      rec_q   <= '0;
    end else if (flush) begin
      valid_q <= 1'b0;
    end else if (complete) begin
      valid_q <= 1'b1;
      addr_q  <= pend_q ? first_addr_q : next_addr_q;
      rec_q   <= built;
    end else if (out_ready) begin
      valid_q <= 1'b0;
    end
  end

  assign out_valid   = valid_q;
  assign out_addr    = addr_q;
  assign out_opcode  = rec_q.opcode;
  assign out_form    = rec_q.form;
  assign out_cond    = rec_q.cond;
  assign out_reg1    = rec_q.reg1;
  assign out_reg2    = rec_q.reg2;
  assign out_imm     = rec_q.imm;
  assign out_subop   = rec_q.subop;
  assign out_ill_op  = rec_q.ill_op;
  assign out_ill_sub = rec_q.ill_sub;

endmodule

// File: rtl/insn_dec_checker.sv
module insn_dec_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              flush,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [ADDR_W-1:0] out_addr,
  input logic [6:0]        out_opcode,
  input logic [2:0]        out_form,
  input logic [3:0]        out_cond,
  input logic [4:0]        out_reg1,
  input logic [4:0]        out_reg2,
  input logic [31:0]       out_imm,
  input logic [5:0]        out_subop,
  input logic              out_ill_op,
  input logic              out_ill_sub
);

  a_r1_no_take_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_record_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !flush) |=> (out_valid &&
      $stable({out_addr, out_opcode, out_form, out_cond, out_reg1, out_reg2,
               out_imm, out_subop, out_ill_op, out_ill_sub})));

  a_r10_flush_blocks_input: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> !in_ready);

  a_r10_flush_drops_record: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !out_valid);

  a_r5_imm5_signext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 3'd2) |-> (out_imm[31:4] == '0 || out_imm[31:4] == '1));

  a_r5_disp9_signext: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 3'd3) |-> (out_imm[31:8] == '0 || out_imm[31:8] == '1));

  a_r4_branch_opcode_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form == 3'd3) |-> (out_opcode[6:4] == 3'b100 && out_opcode[3:0] == out_cond));

  a_r6_undef_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ill_op) |->
      (out_opcode == 7'h1B || out_opcode == 7'h32 || out_opcode == 7'h36));

  a_r3_long_forms: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form >= 3'd4) |-> (out_opcode >= 7'h28 && out_opcode <= 7'h3F));

  a_r8_subop_only_where_used: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_form != 3'd7 && out_opcode != 7'h1F) |-> (out_subop == '0 && !out_ill_sub));

endmodule

bind insn_stream_decoder insn_dec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .flush       (flush),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_opcode  (out_opcode),
  .out_form    (out_form),
  .out_cond    (out_cond),
  .out_reg1    (out_reg1),
  .out_reg2    (out_reg2),
  .out_imm     (out_imm),
  .out_subop   (out_subop),
  .out_ill_op  (out_ill_op),
  .out_ill_sub (out_ill_sub)
);

// File: tb/sim_insn_stream_decoder.sv
`timescale 1ns/1ps
module sim_insn_stream_decoder;

  localparam int          AW = 20;
  localparam logic [AW-1:0] RA = 20'hFFFF0;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          flush = 1'b0;
  logic [AW-1:0] flush_addr = '0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [15:0]   in_half = '0;
  logic          out_valid;
  logic          out_ready = 1'b0;
  logic [AW-1:0] out_addr;
  logic [6:0]    out_opcode;
  logic [2:0]    out_form;
  logic [3:0]    out_cond;
  logic [4:0]    out_reg1;
  logic [4:0]    out_reg2;
  logic [31:0]   out_imm;
  logic [5:0]    out_subop;
  logic          out_ill_op;
  logic          out_ill_sub;

  always #2.5 clk = ~clk;

  insn_stream_decoder #(.ADDR_W(AW), .RESET_ADDR(RA)) u0 (
    .clk(clk), .rst_n(rst_n), .flush(flush), .flush_addr(flush_addr),
    .in_valid(in_valid), .in_ready(in_ready), .in_half(in_half),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_opcode(out_opcode), .out_form(out_form), .out_cond(out_cond),
    .out_reg1(out_reg1), .out_reg2(out_reg2), .out_imm(out_imm),
    .out_subop(out_subop), .out_ill_op(out_ill_op), .out_ill_sub(out_ill_sub)
  );

  typedef struct {
    int          addr;
    int          opc;
    int          form;
    int          cond;
    int          r1;
    int          r2;
    logic [31:0] imm;
    int          sub;
    bit          illop;
    bit          illsub;
  } exp_t;

  int   total = 0;
  int   bad = 0;
  int   cyc = 0;
  bit   done = 0;
  exp_t q[$];
  bit   m_pend = 0;
  logic [15:0]   m_first = '0;
  logic [AW-1:0] m_first_addr = '0;
  logic [AW-1:0] m_addr = RA;
  bit   prev_stall = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int sext(input int v, input int bits);
    int half = 1 << (bits - 1);
    return (v >= half) ? v - 2 * half : v;
  endfunction

  function automatic exp_t model(input logic [15:0] a, input logic [15:0] b,
                                 input logic [AW-1:0] ad);
    exp_t e;
    int op = a[15:10];
    e.addr = ad; e.opc = op; e.cond = 0; e.r1 = a[4:0]; e.r2 = a[9:5];
    e.imm = 0; e.sub = 0; e.illsub = 0;
    e.illop = (op == 'h1B || op == 'h32 || op == 'h36);
    if (op < 'h10) e.form = 1;
    else if (op < 'h20) begin
      e.form = 2;
      e.imm = sext(a[4:0], 5);
      if (op == 'h1F) begin
        e.sub = a[4:0];
        e.illsub = (e.sub >= 4 && e.sub <= 7) || e.sub >= 'h10;
      end
    end else if (op < 'h28) begin
      e.form = 3; e.opc = a[15:9]; e.cond = a[12:9]; e.r1 = 0; e.r2 = 0;
      e.imm = sext(a[8:0], 9);
    end else if (op == 'h2A || op == 'h2B) begin
      e.form = 4; e.r1 = 0; e.r2 = 0;
      e.imm = sext(a[9:0] * 65536 + b, 26);
    end else if (op < 'h30) begin
      e.form = 5; e.imm = sext(b, 16);
    end else if (op == 'h3E) begin
      e.form = 7; e.sub = b[15:10];
      e.illsub = !(e.sub == 0 || (e.sub >= 2 && e.sub <= 7) || e.sub == 'h0B);
    end else begin
      e.form = 6; e.imm = sext(b, 16);
    end
    return e;
  endfunction

  task automatic cmp_rec(input exp_t e);
    chk(out_addr == AW'(e.addr), "R11", "addr", out_addr, e.addr);
    chk(out_opcode == 7'(e.opc), "R4", "opcode", out_opcode, e.opc);
    chk(out_cond == 4'(e.cond), "R4", "cond", out_cond, e.cond);
    chk(out_reg1 == 5'(e.r1) && out_reg2 == 5'(e.r2), "R4", "regs",
        {out_reg2, out_reg1}, e.r2 * 32 + e.r1);
    chk(out_form == 3'(e.form), "R3", "form", out_form, e.form);
    chk(out_imm == e.imm, "R5", "imm", out_imm, e.imm);
    chk(out_ill_op == e.illop, "R6", "ill_op", out_ill_op, e.illop);
    if (e.form == 7)
      chk(out_subop == 6'(e.sub) && out_ill_sub == e.illsub, "R8", "fp sub",
          {out_ill_sub, out_subop}, e.illsub * 64 + e.sub);
    else
      chk(out_subop == 6'(e.sub) && out_ill_sub == e.illsub, "R7", "bs sub",
          {out_ill_sub, out_subop}, e.illsub * 64 + e.sub);
  endtask

  // one cycle: drive at the falling edge, observe the coming handshake, update the model
  task automatic step(input bit iv, input logic [15:0] d, input bit ordy,
                      input bit fl, input logic [AW-1:0] fa);
    bit exp_rdy;
    @(negedge clk);
    in_valid = iv; in_half = d; out_ready = ordy; flush = fl; flush_addr = fa;
    #1;
    exp_rdy = !fl && !(q.size() > 0 && !ordy);
    chk(in_ready == exp_rdy, fl ? "R10" : "R1", "in_ready", in_ready, exp_rdy);
    chk(out_valid == (q.size() > 0), "R2", "out_valid", out_valid, q.size() > 0);
    if (prev_stall) chk(out_valid == 1'b1, "R9", "valid held", out_valid, 1);
    if (out_valid && q.size() > 0) cmp_rec(q[0]);
    prev_stall = (q.size() > 0) && !ordy && !fl;
    if (fl) begin
      q.delete(); m_pend = 0; m_addr = fa;
    end else begin
      if (q.size() > 0 && ordy) void'(q.pop_front());
      if (iv && exp_rdy) begin
        if (m_pend) begin
          q.push_back(model(m_first, d, m_first_addr));
          m_pend = 0;
        end else if (d[15:10] >= 6'h28) begin
          m_pend = 1; m_first = d; m_first_addr = m_addr;
        end else begin
          q.push_back(model(d, 16'h0, m_addr));
        end
        m_addr = m_addr + AW'(2);
      end
    end
  endtask

  task automatic send(input logic [15:0] d);
    step(1, d, 1, 0, '0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=0", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk(out_valid == 1'b0, "R2", "reset out_valid", out_valid, 0);
    rst_n = 1'b1;
    #1;
    chk(in_ready == 1'b1, "R1", "reset in_ready", in_ready, 1);

    // short forms, branch, bit-string sub-opcodes (R7) and undefined codes (R6)
    send({6'h01, 5'd5, 5'd3});
    send({6'h10, 5'd9, 5'b11001});
    send({6'h1F, 5'd0, 5'h05});
    send({6'h1F, 5'd0, 5'h0B});
    send({7'h47, 9'h1FD});
    send({6'h1B, 10'h155});
    // long forms: jr negative (R5), addi, float sub legal / undefined (R8), 0x32
    send({6'h2A, 10'h3FF}); send(16'h8000);
    send({6'h29, 5'd1, 5'd2}); send(16'h8001);
    send({6'h3E, 5'd4, 5'd7}); send({6'h0B, 10'h0});
    send({6'h3E, 5'd4, 5'd7}); send({6'h01, 10'h0});
    send({6'h32, 5'd4, 5'd7}); send(16'h7FFF);
    // gap between halves, then a stall on the result (R9)
    send({6'h2F, 5'd6, 5'd8});
    step(0, 16'hDEAD, 1, 0, '0);
    step(0, 16'hDEAD, 1, 0, '0);
    step(1, 16'h1234, 0, 0, '0);
    for (int i = 0; i < 4; i++) step(1, {6'h00, 10'h3}, 0, 0, '0);
    step(1, {6'h00, 10'h3}, 1, 0, '0);
    // flush between the halves of a long instruction (R10)
    send({6'h2C, 5'd1, 5'd1});
    step(1, 16'h5555, 1, 1, 20'h00100);
    send({6'h0C, 5'd2, 5'd3});
    step(0, 16'h0, 1, 0, '0);
    step(0, 16'h0, 1, 0, '0);

    // random traffic with stalls, gaps and flushes
    for (int i = 0; i < 6000; i++) begin
      logic [AW-1:0] fa;
      fa = AW'($urandom) & ~AW'(1);
      step(($urandom % 4) != 0, 16'($urandom), ($urandom % 3) != 0,
           ($urandom % 50) == 0, fa);
    end
    for (int i = 0; i < 4; i++) step(0, 16'h0, 1, 0, '0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule